// File: doc/BRIEF.md
# 66-bit Block Framer with Scrambler and 16-bit Gearbox

This block carries 64-bit payloads over a 16-bit word stream using 66-bit blocks. On the transmit side each accepted payload gets a two-bit sync header that marks it as data or control. The 64 payload bits are scrambled by a self-synchronous scrambler, and the block is packed into a bit buffer. The buffer emits one 16-bit word per cycle for a later serializer. A 66-bit block does not divide evenly into 16-bit words, so the input side is throttled by a ready signal.

On the receive side 16-bit words are collected into a bit buffer and 66-bit blocks are cut from it. The receiver hunts for block alignment by slipping one bit whenever a header is invalid. It declares lock after a run of valid headers and drops lock when too many headers in a window are bad. While locked it descrambles each block with a validly framed header and presents the payload and the control flag.

Both paths share one clock. They are independent, so the transmit output can be looped back to the receive input.

Top module: `line66_codec`

## Requirements
- R1: The sync header is sent before the payload and is not scrambled. A data block (txCtrl=0) carries header value 2'b01 and a control block carries 2'b10, with header bit 0 transmitted first.
- R2: Payload bits are scrambled LSB first as s[i] = d[i] ^ s[i-39] ^ s[i-58]. The history runs across block boundaries, covers payload bits only, and is all zero after reset.
- R3: Bit 0 of txWord is the earliest bit of the stream. txWordValid is high exactly when at least 16 bits are buffered. After a single block from reset it stays high for four cycles and then drops, leaving 2 bits held.
- R4: A block is accepted (txValid and txReady) only when no more than 16 bits remain after the current word leaves. With txValid held high, the first 363 cycles accept 89 blocks, every later 33-cycle window accepts 8, and txWordValid never drops after the first accept.
- R5: After reset, txReady is 1 and txWordValid, rxValid and rxLock are 0.
- R6: rxLock rises on the 64th consecutive valid header (01 or 10). The first payload presented is the block that follows it.
- R7: While unlocked, every invalid header (00 or 11) discards one extra stream bit. Lock is therefore reached from any starting bit offset.
- R8: While locked, lock drops when 16 invalid headers fall inside one window of 64 blocks. Fewer than 16 leave lock in place.
- R9: The descrambler is fed from the received scrambled bits and recovers the original payload regardless of its starting state. rxCtrl is 1 for header 2'b10. Blocks with an invalid header are never presented.
- R10: rxValid is only raised for a block taken while rxLock was already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rstN | input | 1 | Asynchronous reset, active low |
| txData | input | 64 | Payload to send |
| txCtrl | input | 1 | 1 marks a control block |
| txValid | input | 1 | Payload offered |
| txReady | output | 1 | Buffer has room for a whole block |
| txWord | output | 16 | Outgoing word, bit 0 first |
| txWordValid | output | 1 | txWord carries 16 real bits |
| rxWord | input | 16 | Incoming word, bit 0 first |
| rxWordValid | input | 1 | rxWord carries 16 real bits |
| rxData | output | 64 | Descrambled payload |
| rxCtrl | output | 1 | Received block was a control block |
| rxValid | output | 1 | rxData and rxCtrl valid for this cycle |
| rxLock | output | 1 | Block alignment established |

## Verification
The hardest state to reach is lock acquisition from a misaligned stream while the descrambler holds a history unrelated to the sender's. It also matters that the bad-header window decides lock loss, not a simple run length. The bench builds its own bit stream with a reference scrambler seeded with a nonzero history, prefixes it with five junk bits, and checks that output starts no earlier than 64 blocks into the stream and then tracks the sent payloads exactly. A second stage injects 15 bad headers, which must not unlock. A run of 32 follows, which must unlock whatever the window phase.

// File: rtl/line66_pkg.sv
package line66_pkg;
  localparam int PAY_W   = 64;
  localparam int HDR_W   = 2;
  localparam int BLOCK_W = PAY_W + HDR_W;
  localparam int SCR_LEN = 58;
  localparam int SCR_TAP = 39;

  localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxTake;
    logic rxSlip;
    logic rxEmit;
  } gbStrobe_t;

  typedef struct packed {
    logic [SCR_LEN-1:0] state;
    logic [PAY_W-1:0]   bits;
  } scrOut_t;

  // reverse=0 scrambles (history from outputs), reverse=1 descrambles
  // (history from inputs). hist[SCR_LEN-1] is the newest old bit.
  function automatic scrOut_t scrambleStep(input logic [PAY_W-1:0] din,
                                           input logic [SCR_LEN-1:0] st,
                                           input logic reverse);
    logic [PAY_W+SCR_LEN-1:0] hist;
    scrOut_t r;
    hist = '0;
    hist[SCR_LEN-1:0] = st;
    r = '0;
    for (int i = 0; i < PAY_W; i++) begin
      r.bits[i] = din[i] ^ hist[i+SCR_LEN-SCR_TAP] ^ hist[i];
      hist[SCR_LEN+i] = reverse ? din[i] : r.bits[i];
    end
    r.state = hist[PAY_W+SCR_LEN-1:PAY_W];
    return r;
  endfunction
endpackage

// File: rtl/line66_ctrl.sv
module line66_ctrl
  import line66_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LOCK_GOOD = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64,
  localparam int FILL_W   = $clog2(BLOCK_W + WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txValid,
  input  logic              rxWordValid,
  input  logic [HDR_W-1:0]  rxHdr,
  output gbStrobe_t         stb,
  output logic [FILL_W-1:0] txPos,
  output logic [FILL_W-1:0] rxPos,
  output logic              txReady,
  output logic              txWordValid,
  output logic              rxLock
);
  localparam int GOOD_W = $clog2(LOCK_GOOD);
  localparam int BAD_W  = $clog2(BAD_LIMIT);
  localparam int WIN_W  = $clog2(WIN_LEN);

  logic [FILL_W-1:0] txFill, rxFill, txMid, rxMid, rxDrop;
  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;
  logic [WIN_W-1:0]  winCnt;
  logic              locked, hdrOk;

  always_comb begin
    stb = '0;
    stb.txShift = txFill >= FILL_W'(WORD_W);
    txMid       = txFill - (stb.txShift ? FILL_W'(WORD_W) : '0);
    txReady     = txMid <= FILL_W'(WORD_W);
    stb.txLoad  = txValid && txReady;
    txPos       = txMid;
    txWordValid = stb.txShift;

    hdrOk       = (rxHdr == HDR_DATA) || (rxHdr == HDR_CTRL);
    stb.rxTake  = rxFill >= FILL_W'(BLOCK_W + 1);
    stb.rxSlip  = stb.rxTake && !locked && !hdrOk;
    stb.rxEmit  = stb.rxTake && locked && hdrOk;
    rxDrop      = !stb.rxTake ? '0 :
                  (stb.rxSlip ? FILL_W'(BLOCK_W + 1) : FILL_W'(BLOCK_W));
    rxMid       = rxFill - rxDrop;
    rxPos       = rxMid;
    rxLock      = locked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFill  <= '0;
      rxFill  <= '0;
      locked  <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
      winCnt  <= '0;
    end else begin
      txFill <= txMid + (stb.txLoad ? FILL_W'(BLOCK_W) : '0);
      rxFill <= rxMid + (rxWordValid ? FILL_W'(WORD_W) : '0);
      if (stb.rxTake) begin
        if (!locked) begin
          if (hdrOk) begin
            if (goodCnt == GOOD_W'(LOCK_GOOD - 1)) begin
              locked  <= 1'b1;
              goodCnt <= '0;
              winCnt  <= '0;
              badCnt  <= '0;
            end else begin
              goodCnt <= goodCnt + 1'b1;
            end
          end else begin
            goodCnt <= '0;
          end
        end else begin
          if (!hdrOk && badCnt == BAD_W'(BAD_LIMIT - 1)) begin
            locked <= 1'b0;
            winCnt <= '0;
            badCnt <= '0;
          end else if (winCnt == WIN_W'(WIN_LEN - 1)) begin
            winCnt <= '0;
            badCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
            if (!hdrOk) badCnt <= badCnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/line66_datapath.sv
module line66_datapath
  import line66_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  gbStrobe_t         stb,
  input  logic [FILL_W-1:0] txPos,
  input  logic [FILL_W-1:0] rxPos,
  input  logic [PAY_W-1:0]  txData,
  input  logic              txCtrl,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxWordValid,
  output logic [WORD_W-1:0] txWord,
  output logic [HDR_W-1:0]  rxHdr,
  output logic [PAY_W-1:0]  rxData,
  output logic              rxCtrl,
  output logic              rxValid
);
  localparam int TX_BUF_W = BLOCK_W + WORD_W;
  localparam int RX_BUF_W = BLOCK_W + WORD_W + 1;

  logic [TX_BUF_W-1:0] txBuf, txBufNext;
  logic [RX_BUF_W-1:0] rxBuf, rxBufNext;
  logic [SCR_LEN-1:0]  txState, rxState;
  logic [BLOCK_W-1:0]  txBlock;
  scrOut_t             txScr, rxDesc;

  always_comb begin
    txScr   = scrambleStep(txData, txState, 1'b0);
    txBlock = {txScr.bits, (txCtrl ? HDR_CTRL : HDR_DATA)};
    txBufNext = stb.txShift ? (txBuf >> WORD_W) : txBuf;
    if (stb.txLoad) txBufNext = txBufNext | (TX_BUF_W'(txBlock) << txPos);
    txWord = txBuf[WORD_W-1:0];

    rxHdr  = rxBuf[HDR_W-1:0];
    rxDesc = scrambleStep(rxBuf[BLOCK_W-1:HDR_W], rxState, 1'b1);
    rxBufNext = !stb.rxTake ? rxBuf :
                (rxBuf >> (stb.rxSlip ? BLOCK_W + 1 : BLOCK_W));
    if (rxWordValid) rxBufNext = rxBufNext | (RX_BUF_W'(rxWord) << rxPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      rxBuf   <= '0;
      txState <= '0;
      rxState <= '0;
      rxData  <= '0;
      rxCtrl  <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      txBuf   <= txBufNext;
      rxBuf   <= rxBufNext;
      rxValid <= stb.rxEmit;
      if (stb.txLoad) txState <= txScr.state;
      if (stb.rxTake) rxState <= rxDesc.state;
      if (stb.rxEmit) begin
        rxData <= rxDesc.bits;
        rxCtrl <= (rxHdr == HDR_CTRL);
      end
    end
  end
endmodule

// File: rtl/line66_codec.sv
module line66_codec
  import line66_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LOCK_GOOD = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       txData,
  input  logic              txCtrl,
  input  logic              txValid,
  output logic              txReady,
  output logic [WORD_W-1:0] txWord,
  output logic              txWordValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxWordValid,
  output logic [63:0]       rxData,
  output logic              rxCtrl,
  output logic              rxValid,
  output logic              rxLock
);
  localparam int FILL_W = $clog2(BLOCK_W + WORD_W + 2);

  gbStrobe_t         stb;
  logic [FILL_W-1:0] txPos, rxPos;
  logic [HDR_W-1:0]  rxHdr;

  line66_ctrl #(
    .WORD_W(WORD_W), .LOCK_GOOD(LOCK_GOOD),
    .BAD_LIMIT(BAD_LIMIT), .WIN_LEN(WIN_LEN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .rxWordValid(rxWordValid),
    .rxHdr(rxHdr), .stb(stb), .txPos(txPos), .rxPos(rxPos),
    .txReady(txReady), .txWordValid(txWordValid), .rxLock(rxLock)
  );

  line66_datapath #(.WORD_W(WORD_W), .FILL_W(FILL_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txPos(txPos), .rxPos(rxPos),
    .txData(txData), .txCtrl(txCtrl), .rxWord(rxWord),
    .rxWordValid(rxWordValid), .txWord(txWord), .rxHdr(rxHdr),
    .rxData(rxData), .rxCtrl(rxCtrl), .rxValid(rxValid)
  );
endmodule

// File: rtl/line66_codec_checker.sv
module line66_codec_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic txWordValid,
  input logic rxValid,
  input logic rxLock
);
  // R4: an accepted block leaves at least one full word buffered
  p_accept_then_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> txWordValid);

  // R4: back-pressure only while the buffer is draining
  p_stall_draining_r4: assert property (@(posedge clk) disable iff (!rstN)
    !txReady |-> txWordValid);

  // R10: payload presented only for blocks taken while already locked
  p_emit_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(rxLock));

  // R6: the block completing lock is not presented
  p_lock_rise_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxLock) |-> !rxValid);

  // R8: the block that breaks lock is not presented
  p_lock_fall_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxLock) |-> !rxValid);
endmodule

bind line66_codec line66_codec_checker chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txWordValid(txWordValid), .rxValid(rxValid), .rxLock(rxLock)
);

// File: tb/line66_codec_test.sv
module line66_codec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] txData = '0;
  logic        txCtrl = 1'b0, txValid = 1'b0;
  logic        txReady, txWordValid, rxValid, rxCtrl, rxLock;
  logic [15:0] txWord, rxWordIn;
  logic [63:0] rxData;
  logic        loopMode = 1'b0, drvValid = 1'b0, rxValidIn;
  logic [15:0] drvWord = '0;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [57:0] bh;
  bit          bitQ[$];
  logic [63:0] expD[$], gotD[$];
  logic        expC[$], gotC[$];

  localparam logic [63:0] MIX = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;  // 125 MHz

  assign rxWordIn  = loopMode ? txWord : drvWord;
  assign rxValidIn = loopMode ? txWordValid : drvValid;

  line66_codec uut (
    .clk(clk), .rstN(rstN), .txData(txData), .txCtrl(txCtrl),
    .txValid(txValid), .txReady(txReady), .txWord(txWord),
    .txWordValid(txWordValid), .rxWord(rxWordIn), .rxWordValid(rxValidIn),
    .rxData(rxData), .rxCtrl(rxCtrl), .rxValid(rxValid), .rxLock(rxLock)
  );

  always @(negedge clk) if (rstN && rxValid) begin
    gotD.push_back(rxData);
    gotC.push_back(rxCtrl);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic benchScr(input logic [63:0] d, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      s[i] = d[i] ^ bh[38] ^ bh[57];
      bh = {bh[56:0], s[i]};
    end
  endtask

  task automatic pushBlock(input logic [1:0] hdr, input logic [63:0] d);
    logic [63:0] s;
    benchScr(d, s);
    bitQ.push_back(hdr[0]);
    bitQ.push_back(hdr[1]);
    for (int i = 0; i < 64; i++) bitQ.push_back(s[i]);
  endtask

  task automatic pumpRx();
    while (bitQ.size() >= 16) begin
      @(negedge clk);
      for (int j = 0; j < 16; j++) drvWord[j] = bitQ.pop_front();
      drvValid = 1'b1;
    end
    @(negedge clk);
    drvValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; txValid = 1'b0; drvValid = 1'b0; loopMode = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    bh = '0;
    bitQ.delete(); expD.delete(); expC.delete(); gotD.delete(); gotC.delete();
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chk("R5 txWordValid", 64'(txWordValid), 64'd0);
    chk("R5 txReady", 64'(txReady), 64'd1);
    chk("R5 rxLock", 64'(rxLock), 64'd0);
    chk("R5 rxValid", 64'(rxValid), 64'd0);
  endtask

  task automatic testTxFormat(input logic ctrl, input logic [63:0] d);
    logic [63:0] s;
    logic [65:0] e;
    doReset();
    benchScr(d, s);
    e = {s, (ctrl ? 2'b10 : 2'b01)};
    @(negedge clk);
    txData = d; txCtrl = ctrl; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    chk("R1 header", 64'(txWord[1:0]), 64'(ctrl ? 2'b10 : 2'b01));
    for (int w = 0; w < 4; w++) begin
      chk("R2 scrambled word", 64'(txWord), 64'(e[16*w +: 16]));
      chk("R3 word valid", 64'(txWordValid), 64'd1);
      @(negedge clk);
    end
    chk("R3 partial word held", 64'(txWordValid), 64'd0);
  endtask

  task automatic testLoopRate();
    int n = 0, win = 0, gaps = 0, bad = 0;
    doReset();
    loopMode = 1'b1;
    for (int i = 0; i < 120; i++) begin
      expD.push_back(64'(i) * MIX);
      expC.push_back((i % 7) == 3);
    end
    for (int t = 0; t < 363; t++) begin
      @(negedge clk);
      txData = expD[n]; txCtrl = expC[n]; txValid = 1'b1;
      if (t > 0 && !txWordValid) gaps++;
      if (txReady) begin
        n++;
        if (t >= 330) win++;
      end
    end
    @(negedge clk);
    txValid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R4 blocks in 363 cycles", 64'(n), 64'd89);
    chk("R4 blocks in last 33 cycles", 64'(win), 64'd8);
    chk("R4 continuous output", 64'(gaps), 64'd0);
    chk("R6 output count", 64'(gotD.size() >= 20), 64'd1);
    if (gotD.size() > 0) chk("R6 first output block", gotD[0], expD[64]);
    for (int j = 0; j < gotD.size(); j++)
      if (gotD[j] !== expD[64+j] || gotC[j] !== expC[64+j]) bad++;
    chk("R9 loopback payloads", 64'(bad), 64'd0);
  endtask

  task automatic testOffsetLock();
    int k = -1, bad = 0;
    logic [63:0] d;
    doReset();
    bh = 58'h2_3456_789A_BCDE_F1;
    bitQ.push_back(1); bitQ.push_back(1); bitQ.push_back(0);
    bitQ.push_back(1); bitQ.push_back(0);
    for (int i = 0; i < 200; i++) begin
      d = (64'(i) * MIX) ^ 64'h5555_AAAA_0F0F_F0F0;
      expD.push_back(d);
      expC.push_back((i % 5) == 0);
      pushBlock(((i % 5) == 0) ? 2'b10 : 2'b01, d);
    end
    pumpRx();
    chk("R7 lock from offset", 64'(rxLock), 64'd1);
    chk("R9 output count", 64'(gotD.size() >= 100), 64'd1);
    if (gotD.size() > 0)
      for (int i = 0; i < 200; i++) if (k < 0 && expD[i] === gotD[0]) k = i;
    chk("R6 lock needs 64 headers", 64'(k >= 64), 64'd1);
    for (int j = 0; j < gotD.size(); j++)
      if (k < 0 || k + j >= 200 || gotD[j] !== expD[k+j] || gotC[j] !== expC[k+j]) bad++;
    chk("R9 self-sync payloads", 64'(bad), 64'd0);
  endtask

  task automatic testLockLoss();
    int badSeen = 0;
    gotD.delete(); gotC.delete();
    for (int j = 0; j < 15; j++) pushBlock(2'b11, 64'hDEAD_BEEF_0000_0000 | 64'(j));
    for (int j = 0; j < 30; j++) pushBlock(2'b01, 64'h7000 + 64'(j));
    pumpRx();
    chk("R8 15 bad keep lock", 64'(rxLock), 64'd1);
    for (int j = 0; j < gotD.size(); j++) if (gotD[j][63:32] == 32'hDEAD_BEEF) badSeen++;
    chk("R9 bad blocks hidden", 64'(badSeen), 64'd0);
    chk("R9 good blocks after bad", 64'(gotD.size() >= 29), 64'd1);
    for (int j = 0; j < 32; j++) pushBlock(2'b11, 64'h1234_0000 | 64'(j));
    pumpRx();
    chk("R8 32 bad drop lock", 64'(rxLock), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bh = '0;
    testReset();
    testTxFormat(1'b0, 64'h0123_4567_89AB_CDEF);
    testTxFormat(1'b1, 64'hFEDC_BA98_7654_3210);
    testLoopRate();
    testOffsetLock();
    testLockLoss();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule